// File: doc/BRIEF.md
# Privilege-Filtered Fixed Counter Unit

This block holds two fixed event counters for a processor core: one that advances on every clock and one that advances on each retired instruction. Neither counter is a single register. Each keeps five accumulators, one per execution context: machine, supervisor, user, virtualized supervisor and virtualized user. On each step only the accumulator for the context the core is running in advances. A free-running raw count sits next to them and advances on every step, whatever the context.

Each counter has a 64-bit configuration register with five inhibit bits. A counter read adds up the accumulators whose inhibit bit is clear. When all five inhibit bits are zero, the read returns the raw count instead. An inhibit bit sticks on a write only if its privilege context is implemented, as the extension flag inputs report. The block also has a 32-bit operating mode. In that mode each configuration register and each count is reached as a low half and a high half.

Top module: `privfilt_counters`

## Requirements
- R1: While reset is asserted, and on release, every accumulator, raw count and configuration register is zero, and every read select returns 0.
- R2: The cycle counter steps on every clock edge. The context comes from `priv_mode` and `virt_on`. `priv_mode` 3 selects machine, and `virt_on` is ignored there. `priv_mode` 1 selects supervisor, or virtual supervisor when `virt_on` is 1. `priv_mode` 0 selects user, or virtual user when `virt_on` is 1. `priv_mode` 2 advances no accumulator.
- R3: The instruction counter steps only on edges where `retire` is 1. It uses the same context decode, and its raw count holds when `retire` is 0.
- R4: The inhibit bits of a configuration word sit at machine = bit 62, supervisor = 61, user = 60, virtual supervisor = 59 and virtual user = 58. A 64-bit-mode write stores every other bit exactly as written.
- R5: The machine inhibit bit always sticks. Supervisor needs `has_super` and user needs `has_user`. Virtual supervisor needs `has_hyper` and `has_super`; virtual user needs `has_hyper` and `has_user`. A bit whose context is missing is stored as 0.
- R6: In 32-bit mode (`narrow_xlen`=1), a low-half config write stores `csr_wdata[31:0]` into bits 31:0 with no masking. A high-half write stores `csr_wdata[31:0]` into bits 63:32 under the R5 masking, so the inhibit bits appear at positions 30..26. The low-half read returns bits 31:0 and the high-half read returns bits 63:32, each zero-extended.
- R7: When bits 62:58 of a configuration word are all zero, a count read returns that counter's raw count. For the cycle counter this includes steps spent at `priv_mode` 2.
- R8: When any of bits 62:58 is set, a count read returns the sum of the five accumulators whose inhibit bit is clear.
- R9: A 64-bit-mode count read returns the full 64-bit value. In 32-bit mode the low-half count read returns bits 31:0 and the high-half read returns bits 63:32, each zero-extended.
- R10: A write to any count select changes nothing, and neither does a high-half config write in 64-bit mode. In 64-bit mode every high-half read returns 0.
- R11: `csr_sel` encoding: 0 cycle config low, 1 cycle config high, 2 instruction config low, 3 instruction config high, 4 cycle count low, 5 cycle count high, 6 instruction count low, 7 instruction count high. `csr_rdata` follows the select and state without a clock. A write appears on `csr_rdata` only after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| retire | input | 1 | One instruction retires on this edge |
| priv_mode | input | 2 | Current privilege level (3 M, 1 S, 0 U) |
| virt_on | input | 1 | Core runs in a virtualized context |
| has_user | input | 1 | User mode implemented |
| has_super | input | 1 | Supervisor mode implemented |
| has_hyper | input | 1 | Hypervisor support implemented |
| narrow_xlen | input | 1 | 32-bit operating mode |
| csr_we | input | 1 | Write strobe for the selected register |
| csr_sel | input | 3 | Register select (R11) |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Read data for the current select |

## Verification
Each count includes the edge that just passed, so a count read reflects every rising edge up to and including the most recent one. A configuration write shows up on the read port only after the edge that captures it. Read data has no clock latency: it is a function of the select and the registered state. The bench drives all inputs just after a falling edge and samples `csr_rdata` 1 ns later. Its own per-context model advances on the same rising edges as the design, so every comparison sits half a cycle away from any edge that could move the answer.

// File: rtl/privfilt_pkg.sv
package privfilt_pkg;

    localparam int unsigned DATA_W  = 64;
    localparam int unsigned HALF_W  = DATA_W / 2;
    localparam int unsigned N_MODES = 5;
    localparam int unsigned N_CTR   = 2;
    localparam int unsigned INH_HI  = 62;
    localparam int unsigned INH_LO  = INH_HI - N_MODES + 1;

    // accumulator order; inhibit bit of index i lives at INH_HI - i
    localparam int unsigned IDX_M  = 0;
    localparam int unsigned IDX_S  = 1;
    localparam int unsigned IDX_U  = 2;
    localparam int unsigned IDX_VS = 3;
    localparam int unsigned IDX_VU = 4;

    typedef logic [DATA_W-1:0] word_t;

    // writable-bit mask of a configuration word for the implemented contexts
    function automatic word_t keep_mask(input logic has_u, input logic has_s,
                                        input logic has_h);
        logic [N_MODES-1:0] ok;
        word_t              keep;
        ok[IDX_M]  = 1'b1;
        ok[IDX_S]  = has_s;
        ok[IDX_U]  = has_u;
        ok[IDX_VS] = has_h & has_s;
        ok[IDX_VU] = has_h & has_u;
        keep = '1;
        for (int i = 0; i < N_MODES; i++) begin
            keep[INH_HI - i] = ok[i];
        end
        return keep;
    endfunction

    function automatic logic [N_MODES-1:0] inhibits_of(input word_t cfg);
        logic [N_MODES-1:0] inh;
        for (int i = 0; i < N_MODES; i++) begin
            inh[i] = cfg[INH_HI - i];
        end
        return inh;
    endfunction

endpackage

// File: rtl/privfilt_mode_dec.sv
module privfilt_mode_dec
    import privfilt_pkg::*;
(
    input  logic [1:0]         priv,
    input  logic               virt,
    output logic [N_MODES-1:0] mode_oh
);

    always_comb begin
        mode_oh = '0;
        case (priv)
            2'b11: mode_oh[IDX_M] = 1'b1;
            2'b01: begin
                if (virt) mode_oh[IDX_VS] = 1'b1;
                else      mode_oh[IDX_S]  = 1'b1;
            end
            2'b00: begin
                if (virt) mode_oh[IDX_VU] = 1'b1;
                else      mode_oh[IDX_U]  = 1'b1;
            end
            default: mode_oh = '0;
        endcase
    end

endmodule

// File: rtl/privfilt_acc_bank.sv
module privfilt_acc_bank
    import privfilt_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           step,
    input  logic [N_MODES-1:0]             mode_oh,
    output logic [N_MODES-1:0][DATA_W-1:0] acc,
    output logic [DATA_W-1:0]              raw
);

    typedef struct packed {
        logic [N_MODES-1:0][DATA_W-1:0] acc;
        logic [DATA_W-1:0]              raw;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (step) begin
            bank_d.raw = bank_q.raw + DATA_W'(1);
            for (int m = 0; m < N_MODES; m++) begin
                if (mode_oh[m]) begin
                    bank_d.acc[m] = bank_q.acc[m] + DATA_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign acc = bank_q.acc;
    assign raw = bank_q.raw;

endmodule

// File: rtl/privfilt_cfg_reg.sv
module privfilt_cfg_reg
    import privfilt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              narrow,
    input  logic              has_u,
    input  logic              has_s,
    input  logic              has_h,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cfg
);

    typedef struct packed {
        logic [DATA_W-1:0] val;
    } cfg_t;

    cfg_t  cfg_d, cfg_q;
    word_t keep;

    always_comb begin
        keep  = keep_mask(has_u, has_s, has_h);
        cfg_d = cfg_q;
        if (wr_lo) begin
            if (narrow) cfg_d.val[HALF_W-1:0] = wdata[HALF_W-1:0];
            else        cfg_d.val = wdata & keep;
        end else if (wr_hi && narrow) begin
            cfg_d.val[DATA_W-1:HALF_W] = wdata[HALF_W-1:0] & keep[DATA_W-1:HALF_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q.val;

endmodule

// File: rtl/privfilt_filter_sum.sv
module privfilt_filter_sum
    import privfilt_pkg::*;
(
    input  logic [DATA_W-1:0]              cfg,
    input  logic [N_MODES-1:0][DATA_W-1:0] acc,
    input  logic [DATA_W-1:0]              raw,
    output logic [DATA_W-1:0]              value
);

    logic [N_MODES-1:0] inh;

    always_comb begin
        inh = inhibits_of(cfg);
        if (inh == '0) begin
            value = raw;
        end else begin
            value = '0;
            for (int m = 0; m < N_MODES; m++) begin
                if (!inh[m]) value = value + acc[m];
            end
        end
    end

endmodule

// File: rtl/privfilt_counters.sv
module privfilt_counters
    import privfilt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              retire,
    input  logic [1:0]        priv_mode,
    input  logic              virt_on,
    input  logic              has_user,
    input  logic              has_super,
    input  logic              has_hyper,
    input  logic              narrow_xlen,
    input  logic              csr_we,
    input  logic [2:0]        csr_sel,
    input  logic [DATA_W-1:0] csr_wdata,
    output logic [DATA_W-1:0] csr_rdata
);

    logic [N_MODES-1:0]             mode_oh;
    logic [N_CTR-1:0][DATA_W-1:0]   cfg_w;
    logic [N_CTR-1:0][DATA_W-1:0]   raw_w;
    logic [N_CTR-1:0][DATA_W-1:0]   val_w;

    // select fields: [2] count/config, [1] counter, [0] upper half
    logic sel_cnt, sel_ctr, sel_hi;
    assign sel_cnt = csr_sel[2];
    assign sel_ctr = csr_sel[1];
    assign sel_hi  = csr_sel[0];

    privfilt_mode_dec u_dec (
        .priv    (priv_mode),
        .virt    (virt_on),
        .mode_oh (mode_oh)
    );

    for (genvar g = 0; g < N_CTR; g++) begin : gen_ctr
        logic                           step_g;
        logic                           wr_lo_g, wr_hi_g;
        logic [N_MODES-1:0][DATA_W-1:0] acc_g;

        if (g == 0) begin : g_cycles
            assign step_g = 1'b1;
        end else begin : g_instr
            assign step_g = retire;
        end

        assign wr_lo_g = csr_we && !sel_cnt && (sel_ctr == 1'(g)) && !sel_hi;
        assign wr_hi_g = csr_we && !sel_cnt && (sel_ctr == 1'(g)) &&  sel_hi;

        privfilt_acc_bank u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .step    (step_g),
            .mode_oh (mode_oh),
            .acc     (acc_g),
            .raw     (raw_w[g])
        );

        privfilt_cfg_reg u_cfg (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_lo  (wr_lo_g),
            .wr_hi  (wr_hi_g),
            .narrow (narrow_xlen),
            .has_u  (has_user),
            .has_s  (has_super),
            .has_h  (has_hyper),
            .wdata  (csr_wdata),
            .cfg    (cfg_w[g])
        );

        privfilt_filter_sum u_sum (
            .cfg   (cfg_w[g]),
            .acc   (acc_g),
            .raw   (raw_w[g]),
            .value (val_w[g])
        );
    end

    word_t picked;

    always_comb begin
        picked = sel_cnt ? val_w[sel_ctr] : cfg_w[sel_ctr];
        if (narrow_xlen) begin
            csr_rdata = sel_hi ? {{HALF_W{1'b0}}, picked[DATA_W-1:HALF_W]}
                               : {{HALF_W{1'b0}}, picked[HALF_W-1:0]};
        end else begin
            csr_rdata = sel_hi ? '0 : picked;
        end
    end

endmodule

// File: rtl/privfilt_checker.sv
module privfilt_checker
    import privfilt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              retire,
    input logic              csr_we,
    input logic              narrow_xlen,
    input logic              has_user,
    input logic              has_super,
    input logic              has_hyper,
    input logic [2:0]        csr_sel,
    input logic [DATA_W-1:0] cyc_cfg,
    input logic [DATA_W-1:0] ins_cfg,
    input logic [DATA_W-1:0] cyc_raw,
    input logic [DATA_W-1:0] ins_raw
);

    assert_cycle_raw_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cyc_raw == $past(cyc_raw) + DATA_W'(1));

    assert_instr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !retire |=> $stable(ins_raw));

    assert_instr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> ins_raw == $past(ins_raw) + DATA_W'(1));

    assert_user_inh_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_sel == 3'd0 && !narrow_xlen && !has_user)
        |=> !cyc_cfg[INH_HI - IDX_U]);

    assert_vsup_inh_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_sel == 3'd2 && !narrow_xlen && !(has_hyper && has_super))
        |=> !ins_cfg[INH_HI - IDX_VS]);

    assert_count_write_noop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_sel[2]) |=> ($stable(cyc_cfg) && $stable(ins_cfg)));

endmodule

bind privfilt_counters privfilt_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .retire      (retire),
    .csr_we      (csr_we),
    .narrow_xlen (narrow_xlen),
    .has_user    (has_user),
    .has_super   (has_super),
    .has_hyper   (has_hyper),
    .csr_sel     (csr_sel),
    .cyc_cfg     (cfg_w[0]),
    .ins_cfg     (cfg_w[1]),
    .cyc_raw     (raw_w[0]),
    .ins_raw     (raw_w[1])
);

// File: tb/privfilt_counters_tb.sv
module privfilt_counters_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        retire = 1'b0;
    logic [1:0]  priv_mode = 2'd3;
    logic        virt_on = 1'b0;
    logic        has_user = 1'b1;
    logic        has_super = 1'b1;
    logic        has_hyper = 1'b1;
    logic        narrow_xlen = 1'b0;
    logic        csr_we = 1'b0;
    logic [2:0]  csr_sel = 3'd0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] csr_rdata;

    always #4 clk = ~clk;

    privfilt_counters u_dut (.*);

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // reference model: per-context step counts
    logic [63:0] m_cyc [5];
    logic [63:0] m_ins [5];
    logic [63:0] m_rc, m_ri;
    logic [63:0] e_cfg [2];

    function automatic int ctx_of(input logic [1:0] p, input logic v);
        case (p)
            2'd3:    return 0;
            2'd1:    return v ? 3 : 1;
            2'd0:    return v ? 4 : 2;
            default: return -1;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        int k;
        if (!rst_n) begin
            for (int i = 0; i < 5; i++) begin
                m_cyc[i] = '0;
                m_ins[i] = '0;
            end
            m_rc = '0;
            m_ri = '0;
        end else begin
            k = ctx_of(priv_mode, virt_on);
            m_rc = m_rc + 64'd1;
            if (k >= 0) m_cyc[k] = m_cyc[k] + 64'd1;
            if (retire) begin
                m_ri = m_ri + 64'd1;
                if (k >= 0) m_ins[k] = m_ins[k] + 64'd1;
            end
        end
    end

    function automatic logic [63:0] exp_cnt(input int c);
        logic [63:0] s;
        if (e_cfg[c][62:58] == 5'b0) return (c == 0) ? m_rc : m_ri;
        s = '0;
        for (int i = 0; i < 5; i++) begin
            if (!e_cfg[c][62 - i]) s = s + ((c == 0) ? m_cyc[i] : m_ins[i]);
        end
        return s;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic rd(input logic [2:0] s, output logic [63:0] v);
        csr_sel = s;
        #1;
        v = csr_rdata;
    endtask

    task automatic wr(input logic [2:0] s, input logic [63:0] d);
        @(negedge clk);
        csr_we = 1'b1;
        csr_sel = s;
        csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic run(input logic [1:0] p, input logic v, input int n, input int per);
        priv_mode = p;
        virt_on = v;
        for (int i = 0; i < n; i++) begin
            retire = ((i % per) == 0);
            @(negedge clk);
        end
        retire = 1'b0;
    endtask

    task automatic set_ext(input logic u, input logic s, input logic h);
        has_user = u;
        has_super = s;
        has_hyper = h;
    endtask

    task automatic t_reset;
        logic [63:0] v;
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int s = 0; s < 8; s++) begin
            rd(3'(s), v);
            chk("R1", $sformatf("sel %0d under reset", s), v, 64'd0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        e_cfg[0] = '0;
        e_cfg[1] = '0;
        rd(3'd0, v);
        chk("R1", "cycle config after release", v, 64'd0);
    endtask

    task automatic t_warl;
        logic [63:0] v;
        set_ext(1, 1, 1);
        wr(3'd0, 64'h0000_1234_5678_9abc);
        rd(3'd0, v);
        chk("R4", "plain bits stored", v, 64'h0000_1234_5678_9abc);
        wr(3'd0, '1);
        rd(3'd0, v);
        chk("R5", "all contexts present", v, 64'hffff_ffff_ffff_ffff);
        set_ext(1, 1, 0);
        wr(3'd0, '1);
        rd(3'd0, v);
        chk("R5", "no hypervisor", v, 64'hf3ff_ffff_ffff_ffff);
        set_ext(1, 0, 1);
        wr(3'd2, '1);
        rd(3'd2, v);
        chk("R5", "no supervisor (instr cfg)", v, 64'hd7ff_ffff_ffff_ffff);
        set_ext(0, 0, 0);
        wr(3'd2, '1);
        rd(3'd2, v);
        chk("R5", "machine only", v, 64'hc3ff_ffff_ffff_ffff);
        set_ext(1, 1, 1);
        wr(3'd0, '0);
        wr(3'd2, '0);
        e_cfg[0] = '0;
        e_cfg[1] = '0;
    endtask

    task automatic t_modes;
        logic [63:0] v;
        logic [63:0] pat;
        run(2'd3, 1'b0, 5, 1);
        run(2'd1, 1'b0, 7, 2);
        run(2'd0, 1'b0, 3, 1);
        run(2'd1, 1'b1, 4, 3);
        run(2'd0, 1'b1, 6, 2);
        run(2'd3, 1'b1, 2, 1);
        for (int m = 0; m < 5; m++) begin
            pat = 64'h7c00_0000_0000_0000 & ~(64'd1 << (62 - m));
            wr(3'd0, pat);
            wr(3'd2, pat);
            e_cfg[0] = pat;
            e_cfg[1] = pat;
            rd(3'd4, v);
            chk("R2", $sformatf("cycles of context %0d only", m), v, exp_cnt(0));
            rd(3'd6, v);
            chk("R3", $sformatf("retires of context %0d only", m), v, exp_cnt(1));
        end
        pat = 64'h4400_0000_0000_0000;
        wr(3'd0, pat);
        wr(3'd2, pat);
        e_cfg[0] = pat;
        e_cfg[1] = pat;
        run(2'd0, 1'b1, 5, 1);
        rd(3'd4, v);
        chk("R8", "cycles, M and VU inhibited", v, exp_cnt(0));
        rd(3'd6, v);
        chk("R8", "retires, M and VU inhibited", v, exp_cnt(1));
    endtask

    task automatic t_raw;
        logic [63:0] v;
        wr(3'd0, 64'h0000_0000_0000_00ff);
        e_cfg[0] = 64'h0000_0000_0000_00ff;
        run(2'd2, 1'b0, 6, 1);
        rd(3'd4, v);
        chk("R7", "filter zero gives raw cycles", v, m_rc);
        wr(3'd0, 64'h4000_0000_0000_0000);
        e_cfg[0] = 64'h4000_0000_0000_0000;
        run(2'd2, 1'b0, 4, 1);
        rd(3'd4, v);
        chk("R7", "reserved level not in any context", v, exp_cnt(0));
        wr(3'd2, '0);
        e_cfg[1] = '0;
        rd(3'd6, v);
        chk("R7", "filter zero gives raw retires", v, m_ri);
        priv_mode = 2'd3;
    endtask

    task automatic t_narrow;
        logic [63:0] v;
        logic [63:0] e;
        wr(3'd0, '0);
        e_cfg[0] = '0;
        narrow_xlen = 1'b1;
        set_ext(1, 1, 0);
        wr(3'd0, 64'hffff_ffff_ffff_ffff);
        e_cfg[0] = 64'h0000_0000_ffff_ffff;
        rd(3'd0, v);
        chk("R6", "low half unmasked", v, 64'h0000_0000_ffff_ffff);
        rd(3'd1, v);
        chk("R6", "high half untouched", v, 64'd0);
        rd(3'd4, v);
        chk("R9", "low count, raw", v, {32'd0, m_rc[31:0]});
        wr(3'd1, 64'hffff_ffff_ffff_ffff);
        e_cfg[0] = 64'hf3ff_ffff_ffff_ffff;
        rd(3'd1, v);
        chk("R6", "high half masked", v, 64'h0000_0000_f3ff_ffff);
        run(2'd1, 1'b1, 3, 1);
        rd(3'd4, v);
        e = exp_cnt(0);
        chk("R9", "low count, filtered", v, {32'd0, e[31:0]});
        rd(3'd5, v);
        e = exp_cnt(0);
        chk("R9", "high count, filtered", v, {32'd0, e[63:32]});
        rd(3'd6, v);
        e = exp_cnt(1);
        chk("R9", "instr low count", v, {32'd0, e[31:0]});
        narrow_xlen = 1'b0;
        rd(3'd0, v);
        chk("R6", "full word in wide mode", v, 64'hf3ff_ffff_ffff_ffff);
        set_ext(1, 1, 1);
    endtask

    task automatic t_ignored;
        logic [63:0] v;
        wr(3'd1, 64'd0);
        rd(3'd0, v);
        chk("R10", "wide high cfg write ignored", v, e_cfg[0]);
        rd(3'd1, v);
        chk("R10", "wide high cfg read", v, 64'd0);
        rd(3'd5, v);
        chk("R10", "wide high count read", v, 64'd0);
        wr(3'd4, 64'd0);
        wr(3'd6, 64'h0123_4567_89ab_cdef);
        rd(3'd4, v);
        chk("R10", "cycle count write ignored", v, exp_cnt(0));
        rd(3'd6, v);
        chk("R10", "instr count write ignored", v, exp_cnt(1));
        rd(3'd2, v);
        chk("R10", "instr cfg after count write", v, e_cfg[1]);
    endtask

    task automatic t_timing;
        logic [63:0] v;
        @(negedge clk);
        csr_we = 1'b1;
        csr_sel = 3'd2;
        csr_wdata = 64'h0000_0000_0000_0a5a;
        #1;
        v = csr_rdata;
        chk("R11", "old value before capture edge", v, e_cfg[1]);
        @(negedge clk);
        csr_we = 1'b0;
        e_cfg[1] = 64'h0000_0000_0000_0a5a;
        rd(3'd2, v);
        chk("R11", "new value after capture edge", v, 64'h0000_0000_0000_0a5a);
    endtask

    task automatic finish_up;
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

    initial begin
        t_reset();
        t_warl();
        t_modes();
        t_raw();
        t_narrow();
        t_ignored();
        t_timing();
        finish_up();
    end

endmodule